// File: doc/BRIEF.md
# ADC Sample Record Framer

This block turns converter results into four-byte records for a byte-wide stream. Each sample arrives as a single-cycle strobe that carries a 32-bit conversion word, a 2-bit channel number and the converter's modulator-overflow flag. The block keeps the upper 24 bits of the word and drops the low 8. It builds a status byte and then sends the status byte and three data bytes, most significant first, over a valid/ready byte interface.

A pulse-per-second input marks timing events. A rising edge on it arms a pending event, and the next record carries an event flag in its status byte. The pending event is retired when that status byte is taken. An edge that arrives while an event is already on its way into the stream is remembered separately, so it goes into the record after that one. The status byte also carries a full-scale flag that is set when the truncated value is at either end of the 24-bit range.

The block holds one record at a time. A sample offered while a record is still being sent is discarded and counted in a saturating drop counter.

The control is one state machine with five states. S_IDLE waits for a sample. S_STAT presents the status byte. S_DHI, S_DMID and S_DLO present data bits 31:24, 23:16 and 15:8. The transitions are as follows:
- take: S_IDLE to S_STAT, when a sample is strobed.
- S_STAT to S_DHI, S_DHI to S_DMID and S_DMID to S_DLO, each when the current byte is accepted.
- finish: S_DLO to S_IDLE, when the last byte is accepted.
- In every other case a state stays where it is.

Top module: `smp_rec_framer`

## Requirements
- R1: After reset `byte_valid` is 0 and `drop_cnt` is 0.
- R2: Each record is four bytes in this order: status, word bits 31:24, word bits 23:16, word bits 15:8. Word bits 7:0 never appear. After the fourth byte is accepted, `byte_valid` goes to 0 until the next sample.
- R3: Status bit 7 is the sample's modulator-overflow flag. Status bits 5:4 are the channel number, with bit 5 the upper channel bit. Status bits 6, 3 and 1 are always 0.
- R4: Status bit 0 is 1 exactly when word bits 31:8 equal 0x7FFFFF or 0x800000, and 0 otherwise.
- R5: A rising edge of `pps_in` arms a pending event. A sample accepted while an event is pending gets status bit 2 = 1. The pending event clears when that record's status byte is accepted. An edge in the same cycle as the sample's acceptance goes to the following record.
- R6: While `byte_valid` is 1 and `byte_ready` is 0, `byte_valid` stays 1 and `byte_data` does not change.
- R7: A sample is taken only in S_IDLE. A strobe in any other state increments `drop_cnt`, which saturates at its all-ones value.
- R8: A record accepted with no pending event has status bit 2 = 0. After an event has been delivered, later records carry 0 until a new edge arrives.
- R9: A sample strobed while a record is in flight does not alter any byte of that record.
- R10: Holding `pps_in` high yields one event only. A new event needs a fall and a new rise.
- R11: A `pps_in` edge that arrives after an event-carrying record is taken, but before its status byte is accepted, is not lost: the record that follows also carries status bit 2 = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Single-cycle sample strobe |
| smp_word | input | DATA_W | Raw conversion word |
| smp_chan | input | 2 | Channel number of the sample |
| smp_mflag | input | 1 | Modulator-overflow flag of the sample |
| pps_in | input | 1 | Pulse-per-second level input |
| byte_valid | output | 1 | Output byte is valid |
| byte_ready | input | 1 | Downstream accepts the byte |
| byte_data | output | 8 | Output byte |
| drop_cnt | output | DROP_W | Saturating count of discarded samples |

## Verification
The hardest case to reach is a second pulse-per-second edge that lands in the window after an event-carrying sample has been taken but before its status byte is accepted. The bench reaches it by arming an event, offering a sample, and holding `byte_ready` low while it pulses `pps_in` with the machine parked in S_STAT. It then checks that three records in a row carry the event flag as 1, 1 and 0. Edges that fall in the same cycle as sample acceptance are placed by driving the strobe and the pulse on the same falling edge. Drop-counter saturation is reached with a 3-bit counter and a strobe held high over a long stall.

// File: rtl/smp_rec_pkg.sv
package smp_rec_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_STAT,
        S_DHI,
        S_DMID,
        S_DLO
    } frm_state_e;

    // kept width of a sample; three data bytes per record
    localparam int KEEP_W   = 24;
    localparam int REC_W    = KEEP_W + 8;

    // status byte bit positions (decoded downstream)
    localparam int ST_MFLAG = 7;
    localparam int ST_CH_HI = 5;
    localparam int ST_CH_LO = 4;
    localparam int ST_EVT   = 2;
    localparam int ST_FS    = 0;

endpackage

// File: rtl/smp_rec_pack.sv
module smp_rec_pack
    import smp_rec_pkg::*;
(
    input  logic [KEEP_W-1:0] data_i,
    input  logic [1:0]        chan_i,
    input  logic              mflag_i,
    input  logic              event_i,
    output logic [REC_W-1:0]  rec_o
);

    localparam logic [KEEP_W-1:0] POS_FS = {1'b0, {(KEEP_W-1){1'b1}}};
    localparam logic [KEEP_W-1:0] NEG_FS = {1'b1, {(KEEP_W-1){1'b0}}};

    logic       at_fs;
    logic [7:0] status;

    always_comb begin
        at_fs            = (data_i == POS_FS) || (data_i == NEG_FS);
        status           = 8'h00;
        status[ST_MFLAG] = mflag_i;
        status[ST_CH_HI] = chan_i[1];
        status[ST_CH_LO] = chan_i[0];
        status[ST_EVT]   = event_i;
        status[ST_FS]    = at_fs;
        rec_o            = {status, data_i};
    end

endmodule

// File: rtl/smp_rec_pps.sv
module smp_rec_pps (
    input  logic clk,
    input  logic rst_n,
    input  logic pps_in,
    input  logic take_i,     // sample captured this cycle
    input  logic ev_open_i,  // in-flight record carries event, status not yet taken
    input  logic retire_i,   // status byte of an event record accepted
    output logic pend_o,
    output logic again_o,
    output logic edge_o
);

    logic pps_q;
    logic pend_q;
    logic again_q;

    assign edge_o  = pps_in & ~pps_q;
    assign pend_o  = pend_q;
    assign again_o = again_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pps_q   <= 1'b0;
            pend_q  <= 1'b0;
            again_q <= 1'b0;
        end else begin
            pps_q <= pps_in;
            if (retire_i) begin
                pend_q  <= edge_o | again_q;
                again_q <= 1'b0;
            end else begin
                pend_q  <= pend_q | edge_o;
                again_q <= again_q | (edge_o & ((take_i & pend_q) | ev_open_i));
            end
        end
    end

endmodule

// File: rtl/smp_rec_drop.sv
module smp_rec_drop #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (bump_i && cnt_o != CNT_MAX) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

endmodule

// File: rtl/smp_rec_framer.sv
module smp_rec_framer
    import smp_rec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DROP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_word,
    input  logic [1:0]        smp_chan,
    input  logic              smp_mflag,
    input  logic              pps_in,
    output logic              byte_valid,
    input  logic              byte_ready,
    output logic [7:0]        byte_data,
    output logic [DROP_W-1:0] drop_cnt
);

    localparam int DISC_W = DATA_W - KEEP_W;

    frm_state_e state_q, state_d;

    logic [REC_W-1:0] rec_q;
    logic [REC_W-1:0] rec_new;
    logic             take;
    logic             busy_offer;
    logic             rec_ev;
    logic             ev_open;
    logic             retire;
    logic             pend;
    logic             again;
    logic             pps_edge;
    logic             unused_low;

    assign unused_low = ^smp_word[DISC_W-1:0];

    assign take       = (state_q == S_IDLE) && smp_valid;
    assign busy_offer = (state_q != S_IDLE) && smp_valid;
    assign rec_ev     = rec_q[KEEP_W + ST_EVT];
    assign ev_open    = (state_q == S_STAT) && rec_ev;
    assign retire     = ev_open && byte_ready;

    smp_rec_pack u_pack (
        .data_i  (smp_word[DATA_W-1:DISC_W]),
        .chan_i  (smp_chan),
        .mflag_i (smp_mflag),
        .event_i (pend),
        .rec_o   (rec_new)
    );

    smp_rec_pps u_pps (
        .clk       (clk),
        .rst_n     (rst_n),
        .pps_in    (pps_in),
        .take_i    (take),
        .ev_open_i (ev_open),
        .retire_i  (retire),
        .pend_o    (pend),
        .again_o   (again),
        .edge_o    (pps_edge)
    );

    smp_rec_drop #(.CNT_W(DROP_W)) u_drop (
        .clk    (clk),
        .rst_n  (rst_n),
        .bump_i (busy_offer),
        .cnt_o  (drop_cnt)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            rec_q   <= '0;
        end else begin
            state_q <= state_d;
            if (take) begin
                rec_q <= rec_new;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (smp_valid)  state_d = S_STAT;
            S_STAT: if (byte_ready) state_d = S_DHI;
            S_DHI:  if (byte_ready) state_d = S_DMID;
            S_DMID: if (byte_ready) state_d = S_DLO;
            S_DLO:  if (byte_ready) state_d = S_IDLE;
            default:                state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        byte_valid = 1'b1;
        byte_data  = 8'h00;
        unique case (state_q)
            S_IDLE: byte_valid = 1'b0;
            S_STAT: byte_data  = rec_q[REC_W-1 -: 8];
            S_DHI:  byte_data  = rec_q[KEEP_W-1 -: 8];
            S_DMID: byte_data  = rec_q[KEEP_W-9 -: 8];
            S_DLO:  byte_data  = rec_q[7:0];
            default: byte_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/smp_rec_framer_chk.sv
module smp_rec_framer_chk
    import smp_rec_pkg::*;
#(
    parameter int DROP_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input frm_state_e        state_q,
    input logic              smp_valid,
    input logic              byte_valid,
    input logic              byte_ready,
    input logic [7:0]        byte_data,
    input logic [DROP_W-1:0] drop_cnt,
    input logic              pend,
    input logic              again,
    input logic              pps_edge,
    input logic              retire
);

    localparam logic [DROP_W-1:0] ONE = {{(DROP_W-1){1'b0}}, 1'b1};

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid && !byte_ready |=> byte_valid && $stable(byte_data));

    // R2
    last_byte_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_DLO && byte_ready |=> !byte_valid);

    // R3
    zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_STAT |-> !byte_data[6] && !byte_data[3] && !byte_data[1]);

    // R7
    drop_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && state_q != S_IDLE && drop_cnt != '1
        |=> drop_cnt == $past(drop_cnt) + ONE);

    // R7
    drop_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_cnt != '1 && !(smp_valid && state_q != S_IDLE) |=> $stable(drop_cnt));

    // R5
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retire && !pps_edge && !again |=> !pend);

    // R11
    again_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retire && again |=> pend);

endmodule

bind smp_rec_framer smp_rec_framer_chk #(.DROP_W(DROP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_q    (state_q),
    .smp_valid  (smp_valid),
    .byte_valid (byte_valid),
    .byte_ready (byte_ready),
    .byte_data  (byte_data),
    .drop_cnt   (drop_cnt),
    .pend       (pend),
    .again      (again),
    .pps_edge   (pps_edge),
    .retire     (retire)
);

// File: tb/smp_rec_framer_tb_top.sv
module smp_rec_framer_tb_top;

    localparam int DW = 32;
    localparam int QW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_valid = 1'b0;
    logic [DW-1:0] smp_word = '0;
    logic [1:0]    smp_chan = '0;
    logic          smp_mflag = 1'b0;
    logic          pps_in = 1'b0;
    logic          byte_valid;
    logic          byte_ready = 1'b0;
    logic [7:0]    byte_data;
    logic [QW-1:0] drop_cnt;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    smp_rec_framer #(.DATA_W(DW), .DROP_W(QW)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_valid  (smp_valid),
        .smp_word   (smp_word),
        .smp_chan   (smp_chan),
        .smp_mflag  (smp_mflag),
        .pps_in     (pps_in),
        .byte_valid (byte_valid),
        .byte_ready (byte_ready),
        .byte_data  (byte_data),
        .drop_cnt   (drop_cnt)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a falling edge; strobes one sample for one cycle
    task automatic offer(input logic [31:0] w, input logic [1:0] ch, input logic mf);
        @(negedge clk);
        smp_valid = 1'b1; smp_word = w; smp_chan = ch; smp_mflag = mf;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic pull(input logic [7:0] exp, input int stall, input string req);
        byte_ready = 1'b0;
        for (int k = 0; k < stall; k++) begin
            chk(byte_valid == 1'b1, "R6 valid held", {31'd0, byte_valid}, 32'd1);
            chk(byte_data == exp, "R6 data held", {24'd0, byte_data}, {24'd0, exp});
            @(negedge clk);
        end
        chk(byte_valid == 1'b1, req, {31'd0, byte_valid}, 32'd1);
        chk(byte_data == exp, req, {24'd0, byte_data}, {24'd0, exp});
        byte_ready = 1'b1;
        @(negedge clk);
        byte_ready = 1'b0;
    endtask

    task automatic get_record(input logic [31:0] w, input logic [1:0] ch, input logic mf,
                              input logic ev, input int stall);
        logic       fs;
        logic [7:0] st;
        fs = (w[31:8] == 24'h7FFFFF) || (w[31:8] == 24'h800000);
        st = {mf, 1'b0, ch, 1'b0, ev, 1'b0, fs};
        pull(st, stall, "R3/R4/R5/R8 status");
        pull(w[31:24], stall, "R2 byte1");
        pull(w[23:16], stall, "R2 byte2");
        pull(w[15:8], stall, "R2 byte3");
        chk(byte_valid == 1'b0, "R2 idle after record", {31'd0, byte_valid}, 32'd0);
    endtask

    task automatic pps_pulse();
        pps_in = 1'b1;
        @(negedge clk);
        pps_in = 1'b0;
    endtask

    function automatic logic [31:0] pick_word(input int idx, input int salt);
        case (idx)
            0: return 32'h7FFFFF12;
            1: return 32'h800000FF;
            2: return 32'h7FFFFE00;
            3: return 32'h80000100;
            4: return 32'h00000000;
            5: return 32'hFFFFFFFF;
            default: return (idx * 32'h9E3779B9) ^ (salt * 32'h01234567);
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(byte_valid == 1'b0, "R1 valid in reset", {31'd0, byte_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(byte_valid == 1'b0, "R1 valid after reset", {31'd0, byte_valid}, 32'd0);
        chk(drop_cnt == '0, "R1 drop after reset", {29'd0, drop_cnt}, 32'd0);

        // R2 R3 R4 R8 sweep over channels, flags and words
        for (int ch = 0; ch < 4; ch++) begin
            for (int mf = 0; mf < 2; mf++) begin
                for (int i = 0; i < 10; i++) begin
                    logic [31:0] w;
                    w = pick_word(i, ch * 2 + mf);
                    offer(w, ch[1:0], mf[0]);
                    get_record(w, ch[1:0], mf[0], 1'b0, (i + ch) % 3);
                end
            end
        end
        chk(drop_cnt == '0, "R7 no drops in sweep", {29'd0, drop_cnt}, 32'd0);

        // R5 R8: pulse in idle, then two records
        pps_pulse();
        offer(32'h12345678, 2'd1, 1'b0);
        get_record(32'h12345678, 2'd1, 1'b0, 1'b1, 0);
        offer(32'h0BADF00D, 2'd2, 1'b1);
        get_record(32'h0BADF00D, 2'd2, 1'b1, 1'b0, 1);

        // R5: edge in the acceptance cycle goes to the next record
        @(negedge clk);
        smp_valid = 1'b1; smp_word = 32'hA5A5A5A5; smp_chan = 2'd3; smp_mflag = 1'b0;
        pps_in = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0; pps_in = 1'b0;
        get_record(32'hA5A5A5A5, 2'd3, 1'b0, 1'b0, 0);
        offer(32'h5A5A5A5A, 2'd0, 1'b0);
        get_record(32'h5A5A5A5A, 2'd0, 1'b0, 1'b1, 0);

        // R5: edge while a non-event record sits in status state
        offer(32'h11111111, 2'd2, 1'b0);
        pps_pulse();
        get_record(32'h11111111, 2'd2, 1'b0, 1'b0, 0);
        offer(32'h22222222, 2'd2, 1'b0);
        get_record(32'h22222222, 2'd2, 1'b0, 1'b1, 0);

        // R11: edge between taking an event record and its status acceptance
        pps_pulse();
        offer(32'h33333333, 2'd1, 1'b1);
        pps_pulse();
        get_record(32'h33333333, 2'd1, 1'b1, 1'b1, 1);
        offer(32'h44444444, 2'd1, 1'b0);
        get_record(32'h44444444, 2'd1, 1'b0, 1'b1, 0);
        offer(32'h55555555, 2'd1, 1'b0);
        get_record(32'h55555555, 2'd1, 1'b0, 1'b0, 0);

        // R10: held high gives one event; fall and rise rearms
        pps_in = 1'b1;
        offer(32'h66666666, 2'd0, 1'b0);
        get_record(32'h66666666, 2'd0, 1'b0, 1'b1, 0);
        offer(32'h77777777, 2'd0, 1'b0);
        get_record(32'h77777777, 2'd0, 1'b0, 1'b0, 2);
        offer(32'h88888888, 2'd0, 1'b0);
        get_record(32'h88888888, 2'd0, 1'b0, 1'b0, 0);
        pps_in = 1'b0;
        @(negedge clk);
        pps_pulse();
        offer(32'h99999999, 2'd3, 1'b1);
        get_record(32'h99999999, 2'd3, 1'b1, 1'b1, 0);

        // R7 R9: strobe while busy is dropped and leaves record intact
        offer(32'hCAFEBABE, 2'd2, 1'b0);
        smp_valid = 1'b1; smp_word = 32'h7FFFFF00; smp_chan = 2'd1; smp_mflag = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        chk(drop_cnt == 3'd1, "R7 one drop", {29'd0, drop_cnt}, 32'd1);
        get_record(32'hCAFEBABE, 2'd2, 1'b0, 1'b0, 1);
        chk(drop_cnt == 3'd1, "R7 drop count kept", {29'd0, drop_cnt}, 32'd1);

        // R7 saturation with held strobe during a stall
        offer(32'hDEADBEEF, 2'd1, 1'b1);
        smp_valid = 1'b1; smp_word = 32'h00000001;
        repeat (10) @(negedge clk);
        smp_valid = 1'b0;
        chk(drop_cnt == 3'd7, "R7 drop saturates", {29'd0, drop_cnt}, 32'd7);
        get_record(32'hDEADBEEF, 2'd1, 1'b1, 1'b0, 0);
        chk(drop_cnt == 3'd7, "R7 drop stays saturated", {29'd0, drop_cnt}, 32'd7);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule